// File: doc/BRIEF.md
# Flash Status Register Protection Controller

This block keeps the software status byte of a small serial flash device and decides, request by request, whether a program or erase may go ahead. A command decoder upstream hands it single-cycle strobes: set write-enable, clear write-enable, and status write with a data byte. It also hands it program or erase requests, each with a 16-bit address and an operation code. The block weighs every request against the write-enable latch, the busy flag and the block-protect level. It answers with a grant or a reject one clock later. It also shows the status byte on a plain output for the decoder to shift out on status reads.

Requests use a valid-only stream. `req_valid` is sampled on every rising edge, and each sampled request produces exactly one response, with `resp_valid` high for one cycle on the next edge. There is no back-pressure. The block accepts every request and never stalls. A request that cannot be served is answered with `resp_grant` low. The write-protect pin, the completion inputs and the status byte are plain level or pulse signals.

The status byte has these fields: bit 0 busy, bit 1 write-enable latch, bits 3:2 protect level {BP1,BP0}, bits 5:4 reserved, bit 6 auto-increment mode, bit 7 lock. Operation codes on `req_op`: 0 byte program, 1 auto-increment program, 2 sector erase, 3 block erase, 4 chip erase.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 0x0C: protect level 11, and busy, write-enable, auto-increment and lock all 0.
- R2: Status bits 5:4 always read 0. A status write changes only bits 7, 3 and 2. Busy, write-enable and auto-increment keep their values.
- R3: A write-enable strobe sets bit 1. A write-disable strobe clears bit 1 and bit 6.
- R4: While bit 1 is 0, every program or erase request is rejected and every status write is ignored. In both cases the status byte is left unchanged.
- R5: For byte program (0), auto-increment program (1) and sector erase (2), the protect level blocks these addresses: level 00 blocks nothing, 01 blocks 0xC000-0xFFFF, 10 blocks 0x8000-0xFFFF, and 11 blocks every address.
- R6: A block erase (3) is not blocked by level 01. Levels 10 and 11 block it the same way as in R5.
- R7: A chip erase (4) is granted only when the protect level is 00.
- R8: A request sampled on an edge is answered on the next edge with resp_valid high. If it is granted, busy reads 1 from that same edge.
- R9: While busy is 1, the write-enable, write-disable and status-write strobes have no effect, and every request is rejected.
- R10: An op_done pulse while busy clears busy. For operation codes 0, 2, 3 and 4, the same pulse also clears write-enable.
- R11: A granted auto-increment program sets bit 6. When it completes with aai_last low, bits 1 and 6 stay set. When it completes with aai_last high, both bits clear.
- R12: A status write changes the lock bit and the protect level only when wp_n is 1 or the lock bit is 0. When wp_n is 0 and the lock bit is 1, those bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write-protect pin level, low enables the lock bit |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Byte carried by the status write |
| req_valid | input | 1 | Program or erase request valid |
| req_op | input | 3 | Operation code of the request |
| req_addr | input | 16 | Target address of the request |
| op_done | input | 1 | Pulse: the granted operation has finished |
| aai_last | input | 1 | With op_done: auto-increment reached the top address |
| resp_valid | output | 1 | Response to the request of the previous cycle |
| resp_grant | output | 1 | 1 grant, 0 reject |
| status | output | 8 | Status byte |

## Verification
Requests are made at the addresses just below and just at each protection boundary (0x7FFF/0x8000, 0xBFFF/0xC000). This shows whether the region compare sits on the right bit. The same upper-quarter address is sent as both a sector erase and a block erase, so the exemption for block erase can be told apart from a plain address check. Status writes are sent with the write-protect pin low and high, and with the lock bit set and clear, which separates the pin-and-lock rule from either input alone. Auto-increment completions with and without the last-address flag show whether the latch clears only on the final word.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    OP_BYTE   = 3'd0,
    OP_AAI    = 3'd1,
    OP_SECTOR = 3'd2,
    OP_BLOCK  = 3'd3,
    OP_CHIP   = 3'd4
  } op_e;

  localparam int SR_W    = 8;
  localparam int SR_BUSY = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP0  = 2;
  localparam int SR_BP1  = 3;
  localparam int SR_AAI  = 6;
  localparam int SR_LOCK = 7;
endpackage

// File: rtl/fsr_region_check.sv
module fsr_region_check
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [1:0]        level,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  localparam int TOP_HI = ADDR_W - 1;

  logic [1:0] quarter;
  assign quarter = addr[TOP_HI -: 2];

  always_comb begin
    if (op == OP_CHIP) begin
      blocked = (level != 2'b00);
    end else begin
      unique case (level)
        2'b00:   blocked = 1'b0;
        2'b01:   blocked = (quarter == 2'b11) && (op != OP_BLOCK);
        2'b10:   blocked = quarter[1];
        default: blocked = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fsr_status_regs.sv
module fsr_status_regs
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       wren,
  input  logic       wrdi,
  input  logic       wrsr,
  input  logic [7:0] wrsr_data,
  input  logic       grant,
  input  op_e        grant_op,
  input  logic       op_done,
  input  logic       aai_last,
  output logic       busy_q,
  output logic       wel_q,
  output logic [1:0] level_q,
  output logic       aai_q,
  output logic       lock_q
);
  op_e cur_op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      wel_q    <= 1'b0;
      level_q  <= 2'b11;
      aai_q    <= 1'b0;
      lock_q   <= 1'b0;
      cur_op_q <= OP_BYTE;
    end else if (busy_q) begin
      if (op_done) begin
        busy_q <= 1'b0;
        if (cur_op_q != OP_AAI) begin
          wel_q <= 1'b0;
        end else if (aai_last) begin
          wel_q <= 1'b0;
          aai_q <= 1'b0;
        end
      end
    end else if (grant) begin
      busy_q   <= 1'b1;
      cur_op_q <= grant_op;
      if (grant_op == OP_AAI) aai_q <= 1'b1;
    end else if (wrsr) begin
      if (wel_q && (wp_n || !lock_q)) begin
        level_q <= {wrsr_data[SR_BP1], wrsr_data[SR_BP0]};
        lock_q  <= wrsr_data[SR_LOCK];
      end
    end else if (wrdi) begin
      wel_q <= 1'b0;
      aai_q <= 1'b0;
    end else if (wren) begin
      wel_q <= 1'b1;
    end
  end

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_done) |=> !busy_q); // R10

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && lock_q) |=> ($stable(level_q) && lock_q)); // R12

  AST_BUSY_FREEZES_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !op_done) |=> $stable(wel_q) && $stable(level_q)); // R9
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [SR_W-1:0]   wrsr_data,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              op_done,
  input  logic              aai_last,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [SR_W-1:0]   status
);
  op_e        op;
  logic       blocked;
  logic       grant;
  logic       busy_q, wel_q, aai_q, lock_q;
  logic [1:0] level_q;

  assign op = op_e'(req_op);

  fsr_region_check #(.ADDR_W(ADDR_W)) u_region (
    .level   (level_q),
    .op      (op),
    .addr    (req_addr),
    .blocked (blocked)
  );

  assign grant = req_valid && !busy_q && wel_q && !blocked;

  fsr_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .wren      (cmd_wren),
    .wrdi      (cmd_wrdi),
    .wrsr      (cmd_wrsr),
    .wrsr_data (wrsr_data),
    .grant     (grant),
    .grant_op  (op),
    .op_done   (op_done),
    .aai_last  (aai_last),
    .busy_q    (busy_q),
    .wel_q     (wel_q),
    .level_q   (level_q),
    .aai_q     (aai_q),
    .lock_q    (lock_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= grant;
    end
  end

  always_comb begin
    status          = '0;
    status[SR_BUSY] = busy_q;
    status[SR_WEL]  = wel_q;
    status[SR_BP0]  = level_q[0];
    status[SR_BP1]  = level_q[1];
    status[SR_AAI]  = aai_q;
    status[SR_LOCK] = lock_q;
  end

  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_grant) |-> status[SR_BUSY]); // R8

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!status[SR_WEL] || status[SR_BUSY])) |=> !resp_grant); // R4

  AST_CHIP_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_CHIP && status[SR_BP1 -: 2] != 2'b00) |=> !resp_grant); // R7

  AST_GRANT_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant |-> resp_valid); // R8
endmodule

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
  logic [7:0]  wrsr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic        op_done = 1'b0, aai_last = 1'b0;
  logic        resp_valid, resp_grant;
  logic [7:0]  status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { bit grant; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  flash_sr_guard dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .op_done(op_done), .aai_last(aai_last),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .status(status)
  );

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL resp unexpected: got grant=%0b expected none", resp_grant);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (resp_grant !== e.grant) begin
          bad++;
          $display("FAIL %s grant: got %0b expected %0b", e.tag, resp_grant, e.grant);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; req_valid = 0;
    op_done = 0; aai_last = 0;
  endtask

  task automatic chk(input logic [7:0] exp, input string tag);
    total++;
    if (status !== exp) begin
      bad++;
      $display("FAIL %s status: got %02h expected %02h", tag, status, exp);
    end
  endtask

  task automatic wren();  cmd_wren = 1; step(); endtask
  task automatic wrdi();  cmd_wrdi = 1; step(); endtask
  task automatic wrsr(input logic [7:0] d); cmd_wrsr = 1; wrsr_data = d; step(); endtask
  task automatic done(input bit last); op_done = 1; aai_last = last; step(); endtask
  task automatic req(input int op, input logic [15:0] a, input bit g, input string tag);
    req_valid = 1; req_op = op[2:0]; req_addr = a;
    sb.push_back('{g, tag});
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(8'h0C, "R1 reset");
    req(0, 16'h0000, 0, "R4 no-wel prog");     chk(8'h0C, "R4 prog state");
    wrsr(8'h00);                                chk(8'h0C, "R4 wrsr ignored");
    wren();                                     chk(8'h0E, "R3 wren");
    wrsr(8'hFF);                                chk(8'h8E, "R2 wrsr fields");
    wp_n = 0; wrsr(8'h00);                      chk(8'h8E, "R12 locked");
    wp_n = 1; wrsr(8'h04);                      chk(8'h06, "R12 pin high");
    req(0, 16'hBFFF, 1, "R5 lvl01 below");      chk(8'h07, "R8 busy set");
    done(0);                                    chk(8'h04, "R10 byte done");
    wren(); req(0, 16'hC000, 0, "R5 lvl01 top"); chk(8'h06, "R5 state");
    req(3, 16'hC000, 1, "R6 block exempt");     chk(8'h07, "R6 busy");
    wrdi();                                     chk(8'h07, "R9 wrdi ignored");
    wrsr(8'h00);                                chk(8'h07, "R9 wrsr ignored");
    req(0, 16'h0000, 0, "R9 busy reject");
    done(0);                                    chk(8'h04, "R10 block done");
    wren(); req(2, 16'hF000, 0, "R5 sector top");
    req(4, 16'h0000, 0, "R7 chip lvl01");       chk(8'h06, "R7 state");
    wrsr(8'h08);                                chk(8'h0A, "R12 lvl10");
    req(0, 16'h7FFF, 1, "R5 lvl10 below");      done(0); chk(8'h08, "R10 done2");
    wren(); req(0, 16'h8000, 0, "R5 lvl10 top");
    req(3, 16'h8000, 0, "R6 block lvl10");
    wrsr(8'h0C); req(0, 16'h0000, 0, "R5 lvl11");
    wrsr(8'h00);                                chk(8'h02, "R2 clear lvl");
    req(4, 16'h0000, 1, "R7 chip open");        chk(8'h03, "R7 busy");
    done(0);                                    chk(8'h00, "R10 chip done");
    wren(); req(1, 16'h1000, 1, "R11 aai start"); chk(8'h43, "R11 aai busy");
    done(0);                                    chk(8'h42, "R11 aai mid");
    req(1, 16'h1001, 1, "R11 aai next");        done(1); chk(8'h00, "R11 aai last");
    wren(); req(1, 16'h2000, 1, "R11 aai again"); done(0);
    wrdi();                                     chk(8'h00, "R3 wrdi");
    step(); step();
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R8 missing responses: got %0d left expected 0", sb.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule